// File: doc/BRIEF.md
# UART transmitter with auto-CTS

This block turns bytes written by a host into asynchronous serial characters on a single TX line. A one-byte holding register accepts a write whenever it is empty. The byte then moves into a shift register as soon as the shifter is idle. The shifter sends a low start bit, then the data bits least significant first, then an optional parity bit, then the stop bits. Bit timing comes from an external enable pulse that arrives at sixteen times the baud rate. The block counts these pulses itself and has no divisor of its own.

The character format is set by static inputs: 5 to 8 data bits, parity off, even or odd, and a short or long stop period. With flow control enabled, a character is moved from the holding register into the shifter only while the peer's clear-to-send input is active. A character already on the line always completes. A break input pulls the line low for as long as it is held. Status outputs show whether the holding register is empty, whether the shifter is idle, and whether the transmitter has any work at all.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset `txd` is 1, `hold_empty` is 1, `shift_empty` is 1 and `busy` is 0.
- R2: A character starts with `txd` low for 16 baud ticks, and each following data bit lasts 16 ticks with the least significant bit sent first.
- R3: `char_len` selects the data length: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Bits of the written byte above that length are not sent.
- R4: With `par_en` 0 no parity bit is sent. With `par_en` 1 one parity bit follows the data. When `par_odd` is 0 the total count of ones in the data and parity bits is even. When `par_odd` is 1 that count is odd.
- R5: The stop period is high. It lasts 16 ticks when `stop_long` is 0. When `stop_long` is 1 it lasts 24 ticks for 5-bit characters and 32 ticks for 6-, 7- and 8-bit characters. `shift_empty` is low for exactly the ticks of the whole character.
- R6: A write while `hold_empty` is 1 is stored. A write while `hold_empty` is 0 is dropped: the stored byte is kept and the dropped byte is never sent.
- R7: `hold_empty` falls after an accepted write and rises once the byte has moved to the shifter. `busy` is 1 whenever the holding register is full or the shifter is not idle. A byte waiting in the holding register is sent as the very next character.
- R8: With `flow_en` 1 and `cts` 0, no character starts: `txd` stays high and `shift_empty` stays 1. A character starts within 4 clocks after `cts` rises.
- R9: If `cts` falls during a character, that character finishes with its full stop period, and the next character is held until `cts` returns.
- R10: With `flow_en` 0 the value of `cts` has no effect on when characters start.
- R11: While `brk` is 1, `txd` is 0. When `brk` returns to 0 on an idle line, `txd` is 1 again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle enable pulse at 16x the baud rate |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Byte to transmit |
| char_len | input | 2 | Data length: 0..3 gives 5..8 bits |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| stop_long | input | 1 | Long stop period (1.5 bits for 5-bit characters, 2 bits otherwise) |
| flow_en | input | 1 | Gate each character start on `cts` |
| cts | input | 1 | Peer clear-to-send, active high, asynchronous |
| brk | input | 1 | Force the line low |
| txd | output | 1 | Serial output, idles high |
| busy | output | 1 | Holding register full or shifter active |
| hold_empty | output | 1 | Holding register can take a byte |
| shift_empty | output | 1 | No character in progress |

## Verification
The assertions take the format inputs (`char_len`, `par_en`, `par_odd`, `stop_long`) as constant for the length of a character. They also take `baud_tick` as a single-cycle pulse. The bench changes the format only while `shift_empty` is 1, and it generates the tick from a free-running divide-by-four counter. The `cts` input goes through a two-stage synchronizer, so the CTS property is stated on the synchronized value. The bench leaves several clocks of margin after every `cts` change before it expects a start or the absence of one.

// File: rtl/uart_tx_cts.sv
module uart_tx_cts #(
  parameter int OS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] char_len,
  input  logic       par_en,
  input  logic       par_odd,
  input  logic       stop_long,
  input  logic       flow_en,
  input  logic       cts,
  input  logic       brk,
  output logic       txd,
  output logic       busy,
  output logic       hold_empty,
  output logic       shift_empty
);

  localparam int CW = $clog2(2 * OS);
  localparam logic [CW-1:0] BIT_LAST  = CW'(OS - 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(OS + OS / 2 - 1);
  localparam logic [CW-1:0] TWO_LAST  = CW'(2 * OS - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} st_t;

  st_t           state;
  logic [7:0]    hold_q;
  logic          hold_full;
  logic [7:0]    sh_q;
  logic          par_q;
  logic [2:0]    bit_q;
  logic [CW-1:0] tk_q;
  logic [1:0]    cts_s;

  logic [7:0]    mask;
  logic [2:0]    last_bit;
  logic [CW-1:0] stop_last;
  logic [CW-1:0] cur_last;
  logic          cts_ok;
  logic          load;
  logic          bit_end;

  assign mask      = 8'hFF >> (2'd3 - char_len);
  assign last_bit  = 3'(char_len) + 3'd4;
  assign stop_last = !stop_long ? BIT_LAST : (char_len == 2'd0 ? HALF_LAST : TWO_LAST);
  assign cur_last  = (state == S_STOP) ? stop_last : BIT_LAST;
  assign cts_ok    = !flow_en || cts_s[1];
  assign load      = (state == S_IDLE) && hold_full && cts_ok;
  assign bit_end   = baud_tick && (tk_q == cur_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cts_s <= 2'b00;
    else        cts_s <= {cts_s[0], cts};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q    <= 8'h00;
      hold_full <= 1'b0;
    end else if (wr_en && !hold_full) begin
      hold_q    <= wr_data;
      hold_full <= 1'b1;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sh_q  <= 8'h00;
      par_q <= 1'b0;
      bit_q <= 3'd0;
      tk_q  <= '0;
    end else if (state == S_IDLE) begin
      if (load) begin
        state <= S_START;
        sh_q  <= hold_q & mask;
        par_q <= ^(hold_q & mask) ^ par_odd;
        tk_q  <= '0;
      end
    end else if (baud_tick) begin
      if (!bit_end) begin
        tk_q <= tk_q + 1'b1;
      end else begin
        tk_q <= '0;
        case (state)
          S_START: begin
            state <= S_DATA;
            bit_q <= 3'd0;
          end
          S_DATA: begin
            sh_q <= sh_q >> 1;
            if (bit_q == last_bit) state <= par_en ? S_PAR : S_STOP;
            else                   bit_q <= bit_q + 3'd1;
          end
          S_PAR:   state <= S_STOP;
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    case (state)
      S_START: txd = 1'b0;
      S_DATA:  txd = sh_q[0];
      S_PAR:   txd = par_q;
      default: txd = 1'b1;
    endcase
    if (brk) txd = 1'b0;
  end

  assign hold_empty  = !hold_full;
  assign shift_empty = (state == S_IDLE);
  assign busy        = hold_full || (state != S_IDLE);

  AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && hold_empty |=> !hold_empty);  // R6

  AST_FULL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !hold_empty && !shift_empty |=> $stable(hold_q) && !hold_empty);  // R6

  AST_CTS_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    shift_empty && flow_en && !cts_s[1] |=> shift_empty);  // R8

  AST_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) != S_IDLE) && (state != $past(state)) |-> $past(baud_tick));  // R2

  AST_STOP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_STOP |-> tk_q <= stop_last);  // R5

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    brk |-> !txd);  // R11

  AST_BUSY_COVERS: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_empty || !hold_empty |-> busy);  // R7

endmodule

// File: tb/test_uart_tx_cts.sv
module test_uart_tx_cts;

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [1:0] char_len;
  logic       par_en;
  logic       par_odd;
  logic       stop_long;
  logic       flow_en;
  logic       cts;
  logic       brk;
  logic       txd;
  logic       busy;
  logic       hold_empty;
  logic       shift_empty;

  int checks = 0;
  int errors = 0;
  logic samp [0:511];
  int ncnt = 0;

  uart_tx_cts #(.OS(16)) i_uart_tx_cts (
    .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .char_len(char_len), .par_en(par_en), .par_odd(par_odd), .stop_long(stop_long),
    .flow_en(flow_en), .cts(cts), .brk(brk), .txd(txd), .busy(busy),
    .hold_empty(hold_empty), .shift_empty(shift_empty)
  );

  // data, char_len, par_en, par_odd, stop_long
  localparam logic [12:0] VEC [8] = '{
    {8'hA5, 2'd3, 1'b0, 1'b0, 1'b0},
    {8'h3C, 2'd3, 1'b1, 1'b0, 1'b1},
    {8'hF1, 2'd0, 1'b1, 1'b1, 1'b1},
    {8'hFF, 2'd1, 1'b1, 1'b0, 1'b1},
    {8'h5A, 2'd2, 1'b1, 1'b1, 1'b0},
    {8'h00, 2'd3, 1'b1, 1'b1, 1'b0},
    {8'h81, 2'd0, 1'b0, 1'b0, 1'b1},
    {8'hE7, 2'd2, 1'b1, 1'b0, 1'b1}
  };

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  initial begin
    int div;
    div = 0;
    baud_tick = 1'b0;
    forever begin
      @(posedge clk);
      #1;
      div = (div + 1) % 4;
      baud_tick = (div == 0);
    end
  end

  always @(negedge clk) begin
    if (!shift_empty && baud_tick && ncnt < 512) begin
      samp[ncnt] = txd;
      ncnt = ncnt + 1;
    end
  end

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cfg(input logic [1:0] l, input logic pe, input logic po, input logic sl);
    @(negedge clk);
    char_len = l; par_en = pe; par_odd = po; stop_long = sl;
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_data = d;
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_start;
    while (shift_empty) @(negedge clk);
  endtask

  task automatic wait_end;
    while (!shift_empty) @(negedge clk);
  endtask

  task automatic check_frame(input logic [7:0] d, input logic [1:0] l, input logic pe,
                             input logic po, input logic sl);
    int n;
    int p;
    int st;
    logic [7:0] mask;
    logic [7:0] got;
    logic expp;
    n = 5 + int'(l);
    p = pe ? 1 : 0;
    st = !sl ? 16 : (l == 2'd0 ? 24 : 32);
    mask = 8'hFF >> (3 - int'(l));
    got = 8'h00;
    for (int i = 0; i < n; i++) got[i] = samp[16 * (i + 1) + 8];
    chk(samp[0] == 1'b0 && samp[8] == 1'b0 && samp[15] == 1'b0, "R2", "start bit low",
        int'(samp[8]), 0);
    chk(got == (d & mask), "R3", "data bits lsb first", int'(got), int'(d & mask));
    if (pe) begin
      expp = (^(d & mask)) ^ po;
      chk(samp[16 * (1 + n) + 8] == expp, "R4", "parity bit", int'(samp[16 * (1 + n) + 8]),
          int'(expp));
    end
    chk(samp[16 * (1 + n + p) + 8] == 1'b1 && samp[ncnt - 1] == 1'b1, "R5", "stop level",
        int'(samp[16 * (1 + n + p) + 8]), 1);
    chk(ncnt == 16 * (1 + n + p) + st, "R5", "character tick count", ncnt, 16 * (1 + n + p) + st);
  endtask

  initial begin
    int lowcnt;
    int startcnt;
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; char_len = 2'd3; par_en = 1'b0;
    par_odd = 1'b0; stop_long = 1'b0; flow_en = 1'b0; cts = 1'b0; brk = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(txd == 1'b1, "R1", "txd idle", int'(txd), 1);
    chk(hold_empty == 1'b1, "R1", "hold_empty", int'(hold_empty), 1);
    chk(shift_empty == 1'b1, "R1", "shift_empty", int'(shift_empty), 1);
    chk(busy == 1'b0, "R1", "busy", int'(busy), 0);

    // table of formats
    for (int k = 0; k < 8; k++) begin
      cfg(VEC[k][4:3], VEC[k][2], VEC[k][1], VEC[k][0]);
      ncnt = 0;
      write_byte(VEC[k][12:5]);
      wait_start;
      wait_end;
      check_frame(VEC[k][12:5], VEC[k][4:3], VEC[k][2], VEC[k][1], VEC[k][0]);
    end

    // R8 held by cts, R7 status, R6 drop while full
    cfg(2'd3, 1'b0, 1'b0, 1'b0);
    flow_en = 1'b1;
    cts = 1'b0;
    ncnt = 0;
    write_byte(8'h55);
    chk(hold_empty == 1'b0, "R7", "hold_empty after write", int'(hold_empty), 0);
    chk(busy == 1'b1, "R7", "busy with byte waiting", int'(busy), 1);
    lowcnt = 0;
    startcnt = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (!txd) lowcnt++;
      if (!shift_empty) startcnt++;
    end
    chk(lowcnt == 0, "R8", "txd low cycles while cts off", lowcnt, 0);
    chk(startcnt == 0, "R8", "shifter active cycles while cts off", startcnt, 0);
    write_byte(8'h99);
    chk(hold_empty == 1'b0, "R6", "still full after dropped write", int'(hold_empty), 0);
    @(negedge clk);
    cts = 1'b1;
    startcnt = 0;
    while (shift_empty && startcnt < 10) begin
      @(negedge clk);
      startcnt++;
    end
    chk(startcnt <= 4, "R8", "clocks from cts to start", startcnt, 4);
    chk(hold_empty == 1'b1, "R7", "hold_empty after move to shifter", int'(hold_empty), 1);
    // R9 cts drops mid character
    repeat (100) @(negedge clk);
    cts = 1'b0;
    write_byte(8'h77);
    wait_end;
    check_frame(8'h55, 2'd3, 1'b0, 1'b0, 1'b0);
    startcnt = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (!shift_empty) startcnt++;
    end
    chk(startcnt == 0, "R9", "next character held after cts drop", startcnt, 0);
    chk(hold_empty == 1'b0, "R9", "byte still waiting", int'(hold_empty), 0);
    // R10 flow control off ignores cts
    ncnt = 0;
    flow_en = 1'b0;
    startcnt = 0;
    while (shift_empty && startcnt < 10) begin
      @(negedge clk);
      startcnt++;
    end
    chk(startcnt <= 4, "R10", "clocks to start with cts ignored", startcnt, 4);
    wait_end;
    check_frame(8'h77, 2'd3, 1'b0, 1'b0, 1'b0);

    // R6 and R7 back to back with a dropped third write
    cfg(2'd3, 1'b1, 1'b0, 1'b0);
    ncnt = 0;
    write_byte(8'h12);
    write_byte(8'h34);
    write_byte(8'h56);
    chk(hold_empty == 1'b0, "R6", "holding full after third write", int'(hold_empty), 0);
    wait_start;
    wait_end;
    check_frame(8'h12, 2'd3, 1'b1, 1'b0, 1'b0);
    ncnt = 0;
    wait_start;
    wait_end;
    check_frame(8'h34, 2'd3, 1'b1, 1'b0, 1'b0);
    startcnt = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (!shift_empty) startcnt++;
    end
    chk(startcnt == 0, "R6", "dropped byte never sent", startcnt, 0);
    chk(busy == 1'b0 && hold_empty == 1'b1, "R7", "idle after both characters", int'(busy), 0);

    // R11 break
    brk = 1'b1;
    lowcnt = 0;
    for (int c = 0; c < 50; c++) begin
      @(negedge clk);
      if (txd) lowcnt++;
    end
    chk(lowcnt == 0, "R11", "high cycles during break", lowcnt, 0);
    brk = 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R11", "txd after break", int'(txd), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule